// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block guards a system against a stalled program. Software programs a 16-bit limit, picks one of three tick sources and a divide ratio, clears the count and then turns the timer on. From then on the count climbs by one on every divided tick of the chosen source. If software stops clearing the count, it reaches the limit and the block raises a single-cycle request to reset the chip.

Access is through a small word-indexed register bus with two byte-lane enables. The three tick sources come in as single-cycle enables in the block's own clock domain, one for the peripheral clock, one for the real-time clock and one for an external clock. The divider has six ratios that grow in steps of four.

Top module: `wdog_timer`

## Requirements
- R1: After reset the limit, enable, count and control registers all read zero and `reset_req` is low.
- R2: `bus_word` selects a register (0 limit, 1 enable in bit 0, 2 count, 3 control in bits 5:0). `bus_be[0]` gates bits 7:0 and `bus_be[1]` gates bits 15:8 of a write. Bits that a register lacks read as zero.
- R3: Control bits 2:0 pick the tick source (bit 0 `tick_periph`, bit 1 `tick_rtc`, bit 2 `tick_ext`). Ticks on sources that are not picked do not move the count.
- R4: Control bits 5:3 hold a divide code. Codes 0 to 5 divide the picked source by 1, 4, 16, 64, 256 and 1024. Codes 6 and 7 divide by 1024.
- R5: The count rises by exactly one per divided tick and only while enable bit 0 is 1. Clearing the enable freezes the count.
- R6: When control bits 2:0 have no bit set, or more than one bit set, the count does not advance.
- R7: One cycle after the count equals the limit while enabled, `reset_req` is high for exactly one cycle. The count then stays at the limit until it is written or the timer is disabled.
- R8: A write to the count register loads it. Writing zero restarts the count and re-arms `reset_req`.
- R9: The divider restarts when the timer is disabled or the control register is written, so the first divided tick after either event takes a full divide period.
- R10: Every register reads back its current value through `bus_rdata`, and the count register returns the live count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_word | input | 2 | Register index (byte offset divided by 4) |
| bus_wr | input | 1 | Write strobe for the selected register |
| bus_wdata | input | 16 | Write data |
| bus_be | input | 2 | Byte-lane enables for the write |
| bus_rdata | output | 16 | Read data of the selected register |
| tick_periph | input | 1 | Peripheral clock tick enable |
| tick_rtc | input | 1 | Real-time clock tick enable |
| tick_ext | input | 1 | External clock tick enable |
| reset_req | output | 1 | One-cycle request to reset the chip |

## Verification
Directed runs cover the following cases:
- Steady ticks on the picked source, where the count is checked against the divide ratio.
- Ticks on the other sources only, which must leave the count unchanged.
- Select fields with no bit or two bits set.
- A control rewrite part-way through a divide period, which tells a restarted divider from a free-running one.
- Divide code 6 held for 1023 and then 1024 ticks, which tells the 1024 clamp from a wrap-around.

Constrained random writes and random tick patterns are then compared cycle by cycle against a bench model of the requirements. This exposes wrong ordering between clear, match and enable, wrong byte-lane merges, and request pulses that last more than one cycle.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int DATA_W     = 16;
    localparam int SRC_N      = 3;
    localparam int CODE_W     = 3;
    localparam int STEP_LOG2  = 2;
    localparam int MAX_CODE   = 5;
    localparam int DIV_W      = STEP_LOG2 * MAX_CODE;
    localparam int CTRL_W     = SRC_N + CODE_W;

    typedef enum logic [1:0] {
        REG_LIMIT = 2'd0,
        REG_EN    = 2'd1,
        REG_COUNT = 2'd2,
        REG_CTRL  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic [SRC_N-1:0]  sel;
    } ctrl_t;

    typedef struct packed {
        logic limit_wr;
        logic en_wr;
        logic count_wr;
        logic ctrl_wr;
    } wr_hit_t;

    // Terminal value of the divider for a code; codes above the top one clamp.
    function automatic logic [DIV_W-1:0] div_last(input logic [CODE_W-1:0] code);
        int unsigned eff;
        logic [DIV_W:0] span;
        eff  = (int'(code) > MAX_CODE) ? MAX_CODE : int'(code);
        span = (DIV_W+1)'(1) << (STEP_LOG2 * eff);
        return DIV_W'(span - (DIV_W+1)'(1));
    endfunction

    // Merge write data into an old value under byte-lane enables.
    function automatic logic [DATA_W-1:0] lane_merge(input logic [DATA_W-1:0] old_v,
                                                     input logic [DATA_W-1:0] new_v,
                                                     input logic [DATA_W/8-1:0] be);
        logic [DATA_W-1:0] res;
        res = old_v;
        for (int i = 0; i < DATA_W/8; i++) begin
            if (be[i]) res[i*8 +: 8] = new_v[i*8 +: 8];
        end
        return res;
    endfunction

endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr,
    input  logic [1:0]          word,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [DATA_W/8-1:0] be,
    output logic [DATA_W-1:0]   limit_q,
    output logic                en_q,
    output ctrl_t               ctrl_q,
    output wr_hit_t             hit
);

    reg_sel_e sel;
    assign sel = reg_sel_e'(word);

    always_comb begin
        hit          = '0;
        hit.limit_wr = wr && (sel == REG_LIMIT);
        hit.en_wr    = wr && (sel == REG_EN);
        hit.count_wr = wr && (sel == REG_COUNT);
        hit.ctrl_wr  = wr && (sel == REG_CTRL);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            limit_q <= '0;
            en_q    <= 1'b0;
            ctrl_q  <= '0;
        end else begin
            if (hit.limit_wr) limit_q <= lane_merge(limit_q, wdata, be);
            if (hit.en_wr && be[0]) en_q <= wdata[0];
            if (hit.ctrl_wr && be[0]) ctrl_q <= ctrl_t'(wdata[CTRL_W-1:0]);
        end
    end

endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler
    import wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  ctrl_t            ctrl,
    input  logic             ctrl_wr,
    input  logic [SRC_N-1:0] src_tick,
    output logic             sel_ok,
    output logic             pre_tick
);

    logic [SRC_N-1:0] hit;
    logic             src_live;
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] last;

    for (genvar i = 0; i < SRC_N; i++) begin : g_src
        assign hit[i] = ctrl.sel[i] & src_tick[i];
    end

    assign sel_ok   = $onehot(ctrl.sel);
    assign src_live = sel_ok && (|hit);
    assign last     = div_last(ctrl.code);
    assign pre_tick = en && src_live && (div_q == last);

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
        end else if (!en || ctrl_wr) begin
            div_q <= '0;
        end else if (src_live) begin
            div_q <= (div_q == last) ? '0 : div_q + DIV_W'(1);
        end
    end

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
    import wdt_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    input  logic [DATA_W-1:0]   limit,
    input  logic                pre_tick,
    input  logic                count_wr,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [DATA_W/8-1:0] be,
    output logic [DATA_W-1:0]   count_q,
    output logic                req_q
);

    logic fired_q;
    logic at_limit;

    assign at_limit = (count_q == limit);

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            req_q   <= 1'b0;
            fired_q <= 1'b0;
        end else begin
            if (count_wr) begin
                count_q <= lane_merge(count_q, wdata, be);
            end else if (en && pre_tick && !at_limit) begin
                count_q <= count_q + DATA_W'(1);
            end
            req_q <= en && at_limit && !fired_q;
            if (!en || count_wr) begin
                fired_q <= 1'b0;
            end else if (at_limit) begin
                fired_q <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
    import wdt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  bus_word,
    input  logic        bus_wr,
    input  logic [15:0] bus_wdata,
    input  logic [1:0]  bus_be,
    output logic [15:0] bus_rdata,
    input  logic        tick_periph,
    input  logic        tick_rtc,
    input  logic        tick_ext,
    output logic        reset_req
);

    logic [DATA_W-1:0] limit_q;
    logic              en_q;
    ctrl_t             ctrl_q;
    wr_hit_t           hit;
    logic              sel_ok;
    logic              pre_tick;
    logic [DATA_W-1:0] count_q;
    logic [SRC_N-1:0]  src_tick;

    assign src_tick = {tick_ext, tick_rtc, tick_periph};

    wdt_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr      (bus_wr),
        .word    (bus_word),
        .wdata   (bus_wdata),
        .be      (bus_be),
        .limit_q (limit_q),
        .en_q    (en_q),
        .ctrl_q  (ctrl_q),
        .hit     (hit)
    );

    wdt_prescaler u_pre (
        .clk      (clk),
        .rst      (rst),
        .en       (en_q),
        .ctrl     (ctrl_q),
        .ctrl_wr  (hit.ctrl_wr),
        .src_tick (src_tick),
        .sel_ok   (sel_ok),
        .pre_tick (pre_tick)
    );

    wdt_counter u_cnt (
        .clk      (clk),
        .rst      (rst),
        .en       (en_q),
        .limit    (limit_q),
        .pre_tick (pre_tick),
        .count_wr (hit.count_wr),
        .wdata    (bus_wdata),
        .be       (bus_be),
        .count_q  (count_q),
        .req_q    (reset_req)
    );

    always_comb begin
        unique case (reg_sel_e'(bus_word))
            REG_LIMIT: bus_rdata = limit_q;
            REG_EN:    bus_rdata = {{(DATA_W-1){1'b0}}, en_q};
            REG_COUNT: bus_rdata = count_q;
            REG_CTRL:  bus_rdata = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
            default:   bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk (
    input logic        clk,
    input logic        rst,
    input logic        en,
    input logic        count_wr,
    input logic        sel_ok,
    input logic        pre_tick,
    input logic [15:0] count,
    input logic [15:0] limit,
    input logic        req
);

    AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (rst) req |=> !req); // R7

    AST_REQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst) req |-> $past(en)); // R7

    AST_HOLD_AT_LIMIT: assert property (@(posedge clk) disable iff (rst)
        (count == limit && !count_wr) |=> count == $past(count)); // R7

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        !count_wr |=> (count == $past(count) || count == $past(count) + 16'd1)); // R5

    AST_FROZEN_OFF: assert property (@(posedge clk) disable iff (rst)
        (!en && !count_wr) |=> count == $past(count)); // R5

    AST_BAD_SEL_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        !sel_ok |-> !pre_tick); // R6

endmodule

bind wdog_timer wdog_timer_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .en       (en_q),
    .count_wr (hit.count_wr),
    .sel_ok   (sel_ok),
    .pre_tick (pre_tick),
    .count    (count_q),
    .limit    (limit_q),
    .req      (reset_req)
);

// File: tb/wdog_timer_test.sv
module wdog_timer_test;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  bus_word;
    logic        bus_wr;
    logic [15:0] bus_wdata;
    logic [1:0]  bus_be;
    logic [15:0] bus_rdata;
    logic        tick_periph, tick_rtc, tick_ext;
    logic        reset_req;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    int req_seen = 0;
    bit done     = 1'b0;

    // bench model state
    logic [15:0] m_limit, m_count;
    logic        m_en, m_fired, m_req;
    logic [5:0]  m_ctrl;
    logic [9:0]  m_div;

    always #10 clk = ~clk;

    wdog_timer uut (
        .clk(clk), .rst(rst), .bus_word(bus_word), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_rdata(bus_rdata),
        .tick_periph(tick_periph), .tick_rtc(tick_rtc), .tick_ext(tick_ext),
        .reset_req(reset_req)
    );

    function automatic logic [9:0] m_last(input logic [2:0] c);
        int e;
        e = (int'(c) > 5) ? 5 : int'(c);
        return 10'((1 << (2 * e)) - 1);
    endfunction

    function automatic logic [15:0] m_merge(input logic [15:0] o, input logic [15:0] n,
                                            input logic [1:0] be);
        logic [15:0] r;
        r = o;
        if (be[0]) r[7:0]  = n[7:0];
        if (be[1]) r[15:8] = n[15:8];
        return r;
    endfunction

    function automatic logic [15:0] m_read(input logic [1:0] a);
        case (a)
            2'd0:    return m_limit;
            2'd1:    return {15'd0, m_en};
            2'd2:    return m_count;
            default: return {10'd0, m_ctrl};
        endcase
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // One clock: drive at the falling edge, step the model, compare after the edge.
    task automatic cycle(input logic w, input logic [1:0] a, input logic [15:0] d,
                         input logic [1:0] be, input logic [2:0] t);
        logic        valid, tk, pre, cw;
        logic [9:0]  last, n_div;
        logic [15:0] n_count, n_limit;
        logic        n_en, n_fired, n_req;
        logic [5:0]  n_ctrl;
        bus_wr = w; bus_word = a; bus_wdata = d; bus_be = be;
        {tick_ext, tick_rtc, tick_periph} = t;
        valid = $onehot(m_ctrl[2:0]);
        tk    = valid && (|(m_ctrl[2:0] & t));
        last  = m_last(m_ctrl[5:3]);
        pre   = m_en && tk && (m_div == last);
        cw    = w && (a == 2'd3);
        if (!m_en || cw)  n_div = '0;
        else if (tk)      n_div = (m_div == last) ? '0 : m_div + 10'd1;
        else              n_div = m_div;
        if (w && a == 2'd2)                         n_count = m_merge(m_count, d, be);
        else if (m_en && pre && m_count != m_limit) n_count = m_count + 16'd1;
        else                                        n_count = m_count;
        n_req = m_en && (m_count == m_limit) && !m_fired;
        if (!m_en || (w && a == 2'd2))    n_fired = 1'b0;
        else if (m_count == m_limit)      n_fired = 1'b1;
        else                              n_fired = m_fired;
        n_limit = (w && a == 2'd0) ? m_merge(m_limit, d, be) : m_limit;
        n_en    = (w && a == 2'd1 && be[0]) ? d[0] : m_en;
        n_ctrl  = (cw && be[0]) ? d[5:0] : m_ctrl;
        @(posedge clk);
        @(negedge clk);
        m_div = n_div; m_count = n_count; m_req = n_req; m_fired = n_fired;
        m_limit = n_limit; m_en = n_en; m_ctrl = n_ctrl;
        check("R7 reset_req", {15'd0, reset_req}, {15'd0, m_req});
        check("R10 readback", bus_rdata, m_read(a));
        if (reset_req) req_seen++;
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        cycle(1'b1, a, d, 2'b11, 3'b000);
    endtask

    task automatic rd(input logic [1:0] a, input string req, input logic [15:0] exp);
        cycle(1'b0, a, 16'd0, 2'b00, 3'b000);
        check(req, bus_rdata, exp);
    endtask

    task automatic idle(input int n, input logic [2:0] t);
        for (int i = 0; i < n; i++) cycle(1'b0, 2'd2, 16'd0, 2'b00, t);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            summary();
        end
    end

    initial begin
        void'($urandom(32'd2417));
        rst = 1'b1; bus_wr = 0; bus_word = 0; bus_wdata = 0; bus_be = 0;
        tick_periph = 0; tick_rtc = 0; tick_ext = 0;
        m_limit = 0; m_count = 0; m_en = 0; m_fired = 0; m_req = 0; m_ctrl = 0; m_div = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset values
        check("R1 reset_req", {15'd0, reset_req}, 16'd0);
        for (int a = 0; a < 4; a++) rd(2'(a), "R1 register after reset", 16'd0);

        // R4 / R3 / R5: divide by 4 on the peripheral source
        wr(2'd3, 16'h0009);
        wr(2'd0, 16'd100);
        wr(2'd2, 16'd0);
        wr(2'd1, 16'd1);
        idle(16, 3'b001);
        rd(2'd2, "R4 count after 16 ticks at divide 4", 16'd4);
        idle(12, 3'b110);
        rd(2'd2, "R3 unselected sources ignored", 16'd4);
        wr(2'd3, 16'h0002);
        idle(5, 3'b010);
        rd(2'd2, "R3 rtc source counts", 16'd9);

        // R6 invalid selects
        wr(2'd3, 16'h0003);
        idle(6, 3'b111);
        rd(2'd2, "R6 two sources selected", 16'd9);
        wr(2'd3, 16'h0000);
        idle(4, 3'b111);
        rd(2'd2, "R6 no source selected", 16'd9);

        // R5 enable gating
        wr(2'd3, 16'h0001);
        wr(2'd1, 16'd0);
        idle(5, 3'b001);
        rd(2'd2, "R5 frozen while disabled", 16'd9);
        wr(2'd1, 16'd1);
        idle(3, 3'b001);
        rd(2'd2, "R5 one step per tick", 16'd12);

        // R8 clear, R7 match
        wr(2'd2, 16'd0);
        rd(2'd2, "R8 counter cleared", 16'd0);
        wr(2'd0, 16'd5);
        req_seen = 0;
        idle(12, 3'b001);
        check("R7 single request pulse", 16'(req_seen), 16'd1);
        rd(2'd2, "R7 count holds at limit", 16'd5);
        wr(2'd2, 16'd0);
        req_seen = 0;
        idle(12, 3'b001);
        check("R8 request re-armed after clear", 16'(req_seen), 16'd1);

        // R9 divider restart on control write
        wr(2'd1, 16'd0);
        wr(2'd0, 16'd100);
        wr(2'd3, 16'h0011);
        wr(2'd2, 16'd0);
        wr(2'd1, 16'd1);
        idle(10, 3'b001);
        wr(2'd3, 16'h0011);
        idle(15, 3'b001);
        rd(2'd2, "R9 divider restarted", 16'd0);
        idle(1, 3'b001);
        rd(2'd2, "R9 full period after restart", 16'd1);

        // R4 code 6 clamps to 1024
        wr(2'd1, 16'd0);
        wr(2'd3, 16'h0031);
        wr(2'd2, 16'd0);
        wr(2'd1, 16'd1);
        idle(1023, 3'b001);
        rd(2'd2, "R4 code 6 before 1024 ticks", 16'd0);
        idle(1, 3'b001);
        rd(2'd2, "R4 code 6 at 1024 ticks", 16'd1);

        // R2 byte lanes and field widths
        cycle(1'b1, 2'd0, 16'hABCD, 2'b01, 3'b000);
        rd(2'd0, "R2 low lane only", 16'h00CD);
        cycle(1'b1, 2'd0, 16'h12FF, 2'b10, 3'b000);
        rd(2'd0, "R2 high lane only", 16'h12CD);
        wr(2'd3, 16'hFFC1);
        rd(2'd3, "R2 control upper bits read zero", 16'h0001);
        wr(2'd1, 16'hFFFF);
        rd(2'd1, "R2 enable upper bits read zero", 16'h0001);

        // constrained random against the model (R10, R7)
        for (int i = 0; i < 4000; i++) begin
            logic        w;
            logic [1:0]  a;
            logic [15:0] d;
            logic [2:0]  t;
            w = ($urandom % 10) == 0;
            a = 2'($urandom % 4);
            t = 3'($urandom);
            case (a)
                2'd0:    d = 16'($urandom % 40);
                2'd1:    d = 16'(($urandom % 5) != 0);
                2'd2:    d = (($urandom % 4) == 0) ? 16'($urandom % 30) : 16'd0;
                default: d = {10'd0, 3'($urandom % 3), (($urandom % 6) == 0) ? 3'($urandom)
                                                     : 3'(1 << ($urandom % 3))};
            endcase
            cycle(w, a, d, 2'($urandom % 4) | 2'b01, t);
        end

        done = 1'b1;
        summary();
    end

endmodule